// File: doc/BRIEF.md
# Multiplexed ADC Conversion Controller

This block sits between a host register bus and a multiplexed analog front end with a single converter. Software writes a 16-bit control word that selects which of ten inputs are switched in, which channel is read, and whether an extra settling interval is wanted. Setting the start bit of that word launches exactly one conversion. The block then runs the converter through a start/busy/done/data handshake and captures the result into a data register.

Completion raises a done flag in a status register. An enable register gates that flag onto an interrupt line, and software clears the flag by writing a 1 to its bit. The result is kept as the raw offset-binary code from the converter, so flipping bit 15 gives the two's complement value. Channels 0 to 7 are differential inputs. Channel 8 is tied to a +10 V reference and channel 9 to a 0 V reference, which makes them usable for calibration.

Registers are addressed by a 2-bit address: 0 is the control word, 1 is status, 2 is interrupt enable and 3 is the read-only data register.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all of the following are zero: the control, status, enable and data registers, `irq_o`, `conv_start_o` and `mux_en_o`.
- R2: A write of the control word with bit 0 set, made while idle, raises `conv_start_o` for exactly one cycle, in the cycle after the write. Bit 0 always reads back as 0.
- R3: Control bits 14:5 drive `mux_en_o`, with channel n at bit 5+n. Control bits 4:1 drive `mux_sel_o` as a binary channel number. Both take effect when the write is accepted and are held until the next accepted write. Channel 9 maps to `mux_en_o[9]`.
- R4: When control bit 15 is set with the start bit, the start pulse comes SETTLE_CLKS cycles later than it would without bit 15.
- R5: A `conv_done_i` pulse while waiting for the converter captures `conv_data_i` into the data register and sets status bit 2. Status bit 0 reads 1 from the accepted start until that capture.
- R6: A status write with bit 2 set clears the done flag. A status write with bit 2 clear leaves it unchanged. A completion in the same cycle as a clearing write leaves the flag set.
- R7: `irq_o` is high exactly while both the done flag and enable bit 2 are set. It stays high until the flag is cleared, and it rises if the enable is set after the flag.
- R8: A control write while a conversion is in progress is ignored. The mux outputs and the stored word are unchanged and no further start pulse is issued.
- R9: The data register keeps its value until the next completion. A `conv_done_i` pulse while idle changes neither the data register nor the done flag.
- R10: While `conv_busy_i` is high the start pulse is held back. It is issued in the first cycle that `conv_busy_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| irq_o | output | 1 | Conversion-done interrupt |
| mux_en_o | output | 10 | Per-channel input enables |
| mux_sel_o | output | 4 | Binary read-channel select |
| conv_start_o | output | 1 | Converter start pulse |
| conv_busy_i | input | 1 | Converter not ready for a start |
| conv_done_i | input | 1 | Converter result valid |
| conv_data_i | input | 16 | Converter result, offset binary |

## Verification
The hardest case to reach is a completion and a clearing status write landing in the same clock edge. The bench drives the converter handshake directly from its tasks, so it can place `conv_done_i` in the same cycle as the clearing write. The same direct control is used to issue a control write while the sequencer is waiting for the converter, and to pulse `conv_done_i` while the sequencer is idle. The settling delay is measured by counting cycles from the accepted write to the start pulse, with and without bit 15 set.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned N_CH     = 10;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned START_B  = 0;
  localparam int unsigned SEL_LSB  = 1;
  localparam int unsigned EN_LSB   = 5;
  localparam int unsigned DLY_B    = 15;
  localparam int unsigned DONE_B   = 2;
  localparam int unsigned BUSY_B   = 0;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_IEN  = 2'd2,
    A_DATA = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SETTLE,
    S_LAUNCH,
    S_WAIT
  } seq_state_e;
endpackage

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
  parameter int unsigned SETTLE_CLKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(SETTLE_CLKS + 1);
  localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= RELOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  p_count_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CLKS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              dly_i,
  input  logic              conv_busy_i,
  input  logic              conv_done_i,
  input  logic [WORD_W-1:0] conv_data_i,
  output logic              conv_start_o,
  output logic              busy_o,
  output logic              cap_o,
  output logic [WORD_W-1:0] cap_data_o
);
  seq_state_e state_q, state_d;
  logic       tmr_load, tmr_expired;

  assign tmr_load = (state_q == S_IDLE) && launch_i && dly_i;

  adc_settle_timer #(.SETTLE_CLKS(SETTLE_CLKS)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .expired_o(tmr_expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (launch_i) state_d = dly_i ? S_SETTLE : S_LAUNCH;
      S_SETTLE: if (tmr_expired) state_d = S_LAUNCH;
      S_LAUNCH: if (!conv_busy_i) state_d = S_WAIT;
      S_WAIT:   if (conv_done_i) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign conv_start_o = (state_q == S_LAUNCH) && !conv_busy_i;
  assign busy_o       = (state_q != S_IDLE);
  assign cap_o        = (state_q == S_WAIT) && conv_done_i;
  assign cap_data_o   = conv_data_i;

  p_start_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  p_launch_waits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LAUNCH && conv_busy_i) |=> (state_q == S_LAUNCH));
  p_idle_done_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !launch_i) |=> (state_q == S_IDLE));
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] cap_data_i,
  output logic              launch_o,
  output logic              dly_o,
  output logic [N_CH-1:0]   mux_en_o,
  output logic [SEL_W-1:0]  mux_sel_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] ctrl_q, data_q;
  logic              done_q, ien_q;
  logic              ctrl_wr, stat_clr, ien_wr;

  assign ctrl_wr  = we_i && (addr_i == A_CTRL) && !busy_i;
  assign stat_clr = we_i && (addr_i == A_STAT) && wdata_i[DONE_B];
  assign ien_wr   = we_i && (addr_i == A_IEN);
  assign launch_o = ctrl_wr && wdata_i[START_B];
  assign dly_o    = wdata_i[DLY_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= {wdata_i[WORD_W-1:1], 1'b0};
      if (cap_i)   data_q <= cap_data_i;
      if (cap_i)         done_q <= 1'b1;
      else if (stat_clr) done_q <= 1'b0;
      if (ien_wr)  ien_q <= wdata_i[DONE_B];
    end
  end

  assign mux_en_o  = ctrl_q[EN_LSB +: N_CH];
  assign mux_sel_o = ctrl_q[SEL_LSB +: SEL_W];
  assign irq_o     = done_q & ien_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o = ctrl_q;
      A_STAT: begin
        rdata_o[DONE_B] = done_q;
        rdata_o[BUSY_B] = busy_i;
      end
      A_IEN:  rdata_o[DONE_B] = ien_q;
      A_DATA: rdata_o = data_q;
      default: rdata_o = '0;
    endcase
  end

  p_done_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> done_q);
  p_data_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(data_q));
  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stat_clr && !ien_wr) |=> irq_o);
  p_keep_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !stat_clr) |=> done_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CLKS = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [15:0]  wdata_i,
  output logic [15:0]  rdata_o,
  output logic         irq_o,
  output logic [9:0]   mux_en_o,
  output logic [3:0]   mux_sel_o,
  output logic         conv_start_o,
  input  logic         conv_busy_i,
  input  logic         conv_done_i,
  input  logic [15:0]  conv_data_i
);
  logic              seq_busy, launch, dly, cap;
  logic [WORD_W-1:0] cap_data;

  adc_seq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .busy_i    (seq_busy),
    .cap_i     (cap),
    .cap_data_i(cap_data),
    .launch_o  (launch),
    .dly_o     (dly),
    .mux_en_o  (mux_en_o),
    .mux_sel_o (mux_sel_o),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o)
  );

  adc_seq_fsm #(.SETTLE_CLKS(SETTLE_CLKS)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .dly_i       (dly),
    .conv_busy_i (conv_busy_i),
    .conv_done_i (conv_done_i),
    .conv_data_i (conv_data_i),
    .conv_start_o(conv_start_o),
    .busy_o      (seq_busy),
    .cap_o       (cap),
    .cap_data_o  (cap_data)
  );

  p_busy_write_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_busy && we_i && addr_i == A_CTRL) |=> ($stable(mux_en_o) && $stable(mux_sel_o)));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int SETTLE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic [9:0]  mux_en;
  logic [3:0]  mux_sel;
  logic        conv_start;
  logic        conv_busy = 1'b0;
  logic        conv_done = 1'b0;
  logic [15:0] conv_data = '0;

  int n_total = 0;
  int n_fail  = 0;
  bit ended   = 1'b0;

  always #2 clk = ~clk;

  adc_seq_ctrl #(.SETTLE_CLKS(SETTLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .mux_en_o(mux_en), .mux_sel_o(mux_sel),
    .conv_start_o(conv_start), .conv_busy_i(conv_busy), .conv_done_i(conv_done),
    .conv_data_i(conv_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic finish_conv(input logic [15:0] d);
    @(negedge clk);
    conv_done = 1'b1; conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 start", conv_start, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mux_en", mux_en, 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 status", v, 0);
    rd(2'd2, v); chk("R1 ien", v, 0);
    rd(2'd3, v); chk("R1 data", v, 0);
  endtask

  task automatic t_basic();
    logic [15:0] v;
    wr(2'd0, 16'h0107);                 // ch3 enabled, sel 3, start
    chk("R2 pulse next cycle", conv_start, 1);
    chk("R3 mux_en ch3", mux_en, 10'h008);
    chk("R3 mux_sel", mux_sel, 3);
    step();
    chk("R2 single pulse", conv_start, 0);
    rd(2'd1, v); chk("R5 busy bit", v, 16'h0001);
    rd(2'd0, v); chk("R2 start reads 0", v, 16'h0106);
    finish_conv(16'h8123);
    rd(2'd1, v); chk("R5 done set", v, 16'h0004);
    rd(2'd3, v); chk("R5 data captured", v, 16'h8123);
    chk("R7 irq off when disabled", irq, 0);
  endtask

  task automatic t_clear_irq();
    logic [15:0] v;
    wr(2'd1, 16'hFFFB);
    rd(2'd1, v); chk("R6 write0 keeps done", v, 16'h0004);
    wr(2'd2, 16'h0004);
    chk("R7 irq on enable", irq, 1);
    step(); step(); step();
    chk("R7 irq held", irq, 1);
    wr(2'd1, 16'h0004);
    chk("R7 irq drops on clear", irq, 0);
    rd(2'd1, v); chk("R6 clear", v, 16'h0000);
  endtask

  task automatic t_delay();
    logic [15:0] v;
    int n;
    wr(2'd0, 16'hC013);                 // ch9 enabled, sel 9, delay, start
    chk("R3 ref channel 9 enable", mux_en, 10'h200);
    chk("R3 sel 9", mux_sel, 9);
    n = 0;
    while (!conv_start && n < 100) begin step(); n++; end
    chk("R4 settle cycles", n, SETTLE);
    finish_conv(16'h0042);
    chk("R7 irq with enable", irq, 1);
    rd(2'd3, v); chk("R5 data ch9", v, 16'h0042);
    wr(2'd1, 16'h0004);
  endtask

  task automatic t_busy_write();
    logic [15:0] v;
    int seen;
    wr(2'd0, 16'h0021);                 // ch0, sel 0, start
    step();
    wr(2'd0, 16'h4013);                 // ignored
    chk("R8 mux_en kept", mux_en, 10'h001);
    chk("R8 mux_sel kept", mux_sel, 0);
    seen = 0;
    for (int i = 0; i < 4; i++) begin if (conv_start) seen++; step(); end
    chk("R8 no extra start", seen, 0);
    finish_conv(16'h1234);
    seen = 0;
    for (int i = 0; i < 4; i++) begin if (conv_start) seen++; step(); end
    chk("R8 no start after done", seen, 0);
    rd(2'd0, v); chk("R8 ctrl kept", v, 16'h0020);
    wr(2'd1, 16'h0004);
  endtask

  task automatic t_conv_busy();
    int seen;
    conv_busy = 1'b1;
    wr(2'd0, 16'h0041);
    seen = 0;
    for (int i = 0; i < 3; i++) begin if (conv_start) seen++; step(); end
    chk("R10 held while busy", seen, 0);
    conv_busy = 1'b0;
    #1 chk("R10 start when ready", conv_start, 1);
    finish_conv(16'h0001);
    wr(2'd1, 16'h0004);
  endtask

  task automatic t_same_cycle();
    logic [15:0] v;
    wr(2'd0, 16'h0041);
    step();
    @(negedge clk);
    we = 1'b1; addr = 2'd1; wdata = 16'h0004;
    conv_done = 1'b1; conv_data = 16'hBEEF;
    @(negedge clk);
    we = 1'b0; conv_done = 1'b0;
    rd(2'd1, v); chk("R6 set wins over clear", v, 16'h0004);
    wr(2'd1, 16'h0004);
    rd(2'd1, v); chk("R6 cleared after", v, 16'h0000);
  endtask

  task automatic t_stray_done();
    logic [15:0] v;
    finish_conv(16'h7777);
    rd(2'd3, v); chk("R9 idle done ignored data", v, 16'hBEEF);
    rd(2'd1, v); chk("R9 idle done ignored flag", v, 16'h0000);
    chk("R9 irq stays low", irq, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_clear_irq();
    t_delay();
    t_busy_write();
    t_conv_busy();
    t_same_cycle();
    t_stray_done();
    finish_run();
  end
endmodule